// File: doc/BRIEF.md
# SATA Host Port Register and Interrupt File

This block is the software-visible register file of a multi-port SATA host controller. A host bus master reaches it through single-cycle read and write strobes carrying a word address and 32-bit data. The block holds a small global group and one register group per port: capabilities, global control, global interrupt summary, implemented-port mask and version, plus each port's list and receive-area base addresses, interrupt status and enable, command, task-file, signature, link status and control, error, active tags and command issue. Every register applies its own write rule: write-one-to-clear, OR-set, masked store, or clear on read.

Per-port enabled interrupt causes are folded into a sticky global summary, which drives one interrupt line. The block does not run commands, write FIS frames or move data. Those blocks feed it event, error, completion and issue-clear vectors. In return it gives them the issued-command vector and one-cycle start, receive-enable and port-reset pulses.

The access port has no back-pressure. Every strobe is accepted in the cycle it is seen. Read data is combinational from the address while `rd_en` is high, and a read's side effect takes place at the closing edge.

Top module: `sata_hba_regs`

## Requirements
- R1: Addresses below 0x100 select the global group (capabilities 0x00, control 0x04, interrupt summary 0x08, implemented ports 0x0C, version 0x10). Port p occupies 0x100+p*0x80, with local offsets 0x00/0x04 list base low/high, 0x08/0x0C receive base low/high, 0x10 interrupt status, 0x14 interrupt enable, 0x18 command, 0x20 task-file (16 bits), 0x24 signature, 0x28 link status, 0x2C link control, 0x30 error, 0x34 active tags and 0x38 command issue. An address past the last implemented port, or an unknown offset, reads 0 and ignores writes.
- R2: A write whose address has either of its two low bits set changes nothing.
- R3: A port interrupt-status write clears every bit written as 1. Bits on that port's event input are set in the same edge and win over the clear.
- R4: A port interrupt-enable write stores the written value ANDed with 0xFDC000FF.
- R5: Global summary bit p is set at the same edge at which port p's next status and next enable share a set bit. It stays set until software writes 1 to it, and it sets again at once if the port is still pending.
- R6: The interrupt output is high exactly when the summary is nonzero and control bit 1 (interrupt enable) is set.
- R7: A control write with bit 0 set resets the controller. Control and the summary become 0, every port's status, enable, link control, error, active tags and completion record are cleared, and every port-reset pulse fires. Any other control write stores bits 1:0 and reads back with bit 31 set.
- R8: A command write stores the value with bits 15 and 14 replaced: bit 15 copies start (bit 0) and bit 14 copies receive-enable (bit 4). A write with bit 0 set gives a one-cycle start pulse. The command register resets to 0x6.
- R9: A command write with bit 4 set gives a one-cycle receive pulse only on the first such write since the last port or controller reset.
- R10: Command-issue writes OR into the register, and the issue-clear input removes bits. Active-tag writes OR in. Error writes clear the bits written as 1, and the error input sets bits.
- R11: A link-control write whose low nibble goes from 1 to 0 gives a one-cycle port-reset pulse. That port's status, enable, error, active tags and completion record are cleared, and link control stores the written value. No other transition gives a pulse.
- R12: A read of active tags returns them with the recorded completions removed. The register keeps that value and the completion record empties. Completion input bits accumulate in the record.
- R13: Link status reads 0x113 when the port's device-present input is high and 0 otherwise. Writes to it are ignored.
- R14: Capabilities read (ports−1) in bits 4:0, 31 in bits 12:8, 1 in bits 23:20, and set bits 18 and 30. Implemented ports reads (1<<ports)−1. Version reads 0x00010000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | write strobe, one access per cycle |
| rd_en | input | 1 | read strobe; triggers read side effects |
| addr | input | AW | byte address |
| wdata | input | 32 | write data |
| rdata | output | 32 | read data, combinational from addr |
| dev_present | input | NP | device attached, per port |
| irq_evt | input | NP*32 | interrupt-cause set bits, 32 per port |
| err_evt | input | NP*32 | error-register set bits |
| fin_set | input | NP*32 | completed-tag bits for the completion record |
| ci_clr | input | NP*32 | command-issue clear bits from the engine |
| irq | output | 1 | controller interrupt level |
| ci_o | output | NP*32 | command-issue registers |
| port_start_o | output | NP | start pulse |
| port_fisrx_o | output | NP | first receive-enable pulse |
| port_rst_o | output | NP | port reset pulse |

## Verification
The properties assume that `wr_en` and `rd_en` are never high together and that the engine's issue-clear vector is quiet in any cycle a property uses to watch command issue. Without that, an unaligned write or an issue write cannot be told apart from an engine clear. The bench drives each access with its own task, one strobe per cycle, and holds every engine vector at zero except for single-cycle pulses given apart from register accesses. The read of active tags is held for one cycle only, so its clear-on-read acts once per read.

// File: rtl/sata_hba_pkg.sv
package sata_hba_pkg;
  localparam int PORT_BASE  = 'h100;
  localparam int PORT_SHIFT = 7;

  typedef enum logic [6:0] {
    P_CLB = 7'h00, P_CLBU = 7'h04, P_FB = 7'h08, P_FBU = 7'h0C,
    P_IS = 7'h10, P_IE = 7'h14, P_CMD = 7'h18, P_TFD = 7'h20,
    P_SIG = 7'h24, P_SSTS = 7'h28, P_SCTL = 7'h2C, P_SERR = 7'h30,
    P_SACT = 7'h34, P_CI = 7'h38
  } port_off_e;

  typedef enum logic [7:0] {
    G_CAP = 8'h00, G_CTL = 8'h04, G_SUM = 8'h08, G_IMPL = 8'h0C, G_VER = 8'h10
  } glob_off_e;

  localparam int CMD_ST  = 0;
  localparam int CMD_FRE = 4;
  localparam int CMD_FR  = 14;
  localparam int CMD_CR  = 15;
  localparam int CTL_RST = 0;
  localparam int CTL_IE  = 1;
  localparam int CTL_AE  = 31;

  localparam logic [31:0] IE_KEEP   = 32'hFDC0_00FF;
  localparam logic [31:0] CMD_INIT  = 32'h0000_0006;
  localparam logic [31:0] LINK_UP   = 32'h0000_0113;
  localparam logic [31:0] VER_VALUE = 32'h0001_0000;

  function automatic logic [31:0] cmd_written(input logic [31:0] w);
    logic [31:0] c;
    c = w;
    c[CMD_CR] = w[CMD_ST];
    c[CMD_FR] = w[CMD_FRE];
    return c;
  endfunction
endpackage

// File: rtl/sata_port_regs.sv
module sata_port_regs
  import sata_hba_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hba_rst,
  input  logic        wr,
  input  logic        rd,
  input  logic [6:0]  off,
  input  logic [31:0] wdata,
  input  logic        dev_present,
  input  logic [31:0] evt,
  input  logic [31:0] err_in,
  input  logic [31:0] fin_in,
  input  logic [31:0] ci_clr,
  output logic [31:0] rdata,
  output logic        pend_nx,
  output logic [31:0] ci,
  output logic        start_p,
  output logic        fisrx_p,
  output logic        prst_p
);
  logic [31:0] clb_q, clbu_q, fb_q, fbu_q, is_q, ie_q, cmd_q, sig_q;
  logic [31:0] sctl_q, serr_q, sact_q, ci_q, fin_q;
  logic [15:0] tfd_q;
  logic        fis_sent_q;

  logic [31:0] is_nx, ie_nx, serr_nx, sact_nx, fin_nx, ci_nx;
  logic        det_fall, port_clr, sact_rd, fis_fire;

  always_comb begin
    det_fall = wr && (off == P_SCTL) && (sctl_q[3:0] == 4'd1) && (wdata[3:0] == 4'd0);
    port_clr = hba_rst || det_fall;
    sact_rd  = rd && (off == P_SACT);
    fis_fire = wr && (off == P_CMD) && wdata[CMD_FRE] && !fis_sent_q;

    is_nx   = port_clr ? '0 :
              ((is_q & ~((wr && off == P_IS) ? wdata : 32'h0)) | evt);
    ie_nx   = port_clr ? '0 : ((wr && off == P_IE) ? (wdata & IE_KEEP) : ie_q);
    serr_nx = port_clr ? '0 :
              ((serr_q & ~((wr && off == P_SERR) ? wdata : 32'h0)) | err_in);
    if (port_clr)                    sact_nx = '0;
    else if (sact_rd)                sact_nx = sact_q & ~fin_q;
    else if (wr && off == P_SACT)    sact_nx = sact_q | wdata;
    else                             sact_nx = sact_q;
    fin_nx  = port_clr ? '0 : (sact_rd ? fin_in : (fin_q | fin_in));
    ci_nx   = (ci_q & ~ci_clr) | ((wr && off == P_CI) ? wdata : 32'h0);
    pend_nx = |(is_nx & ie_nx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clb_q <= '0; clbu_q <= '0; fb_q <= '0; fbu_q <= '0;
      is_q <= '0; ie_q <= '0; cmd_q <= CMD_INIT; sig_q <= '0; tfd_q <= '0;
      sctl_q <= '0; serr_q <= '0; sact_q <= '0; ci_q <= '0; fin_q <= '0;
      fis_sent_q <= 1'b0;
      start_p <= 1'b0; fisrx_p <= 1'b0; prst_p <= 1'b0;
    end else begin
      is_q   <= is_nx;
      ie_q   <= ie_nx;
      serr_q <= serr_nx;
      sact_q <= sact_nx;
      fin_q  <= fin_nx;
      ci_q   <= ci_nx;
      if (wr && off == P_CLB)  clb_q  <= wdata;
      if (wr && off == P_CLBU) clbu_q <= wdata;
      if (wr && off == P_FB)   fb_q   <= wdata;
      if (wr && off == P_FBU)  fbu_q  <= wdata;
      if (wr && off == P_SIG)  sig_q  <= wdata;
      if (wr && off == P_TFD)  tfd_q  <= wdata[15:0];
      if (wr && off == P_CMD)  cmd_q  <= cmd_written(wdata);
      if (hba_rst)                  sctl_q <= '0;
      else if (wr && off == P_SCTL) sctl_q <= wdata;
      if (port_clr)      fis_sent_q <= 1'b0;
      else if (fis_fire) fis_sent_q <= 1'b1;
      start_p <= wr && (off == P_CMD) && wdata[CMD_ST];
      fisrx_p <= fis_fire;
      prst_p  <= port_clr;
    end
  end

  always_comb begin
    case (off)
      P_CLB:  rdata = clb_q;
      P_CLBU: rdata = clbu_q;
      P_FB:   rdata = fb_q;
      P_FBU:  rdata = fbu_q;
      P_IS:   rdata = is_q;
      P_IE:   rdata = ie_q;
      P_CMD:  rdata = cmd_q;
      P_TFD:  rdata = {16'h0, tfd_q};
      P_SIG:  rdata = sig_q;
      P_SSTS: rdata = dev_present ? LINK_UP : 32'h0;
      P_SCTL: rdata = sctl_q;
      P_SERR: rdata = serr_q;
      P_SACT: rdata = sact_q & ~fin_q;
      P_CI:   rdata = ci_q;
      default: rdata = 32'h0;
    endcase
  end

  assign ci = ci_q;
endmodule

// File: rtl/sata_hba_global.sv
module sata_hba_global
  import sata_hba_pkg::*;
#(
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [7:0]    off,
  input  logic [31:0]   wdata,
  input  logic [NP-1:0] pend_nx,
  output logic [31:0]   rdata,
  output logic          hba_rst,
  output logic          irq,
  output logic [NP-1:0] gis,
  output logic [31:0]   ghc
);
  localparam logic [31:0] CAP_VALUE = 32'(NP - 1) | (32'd31 << 8) | (32'd1 << 20)
                                    | (32'd1 << 18) | (32'd1 << 30);
  localparam logic [31:0] IMPL_VALUE = 32'((64'd1 << NP) - 64'd1);

  logic [NP-1:0] sum_clr;

  always_comb begin
    hba_rst = wr && (off == G_CTL) && wdata[CTL_RST];
    sum_clr = (wr && off == G_SUM) ? wdata[NP-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gis <= '0;
      ghc <= '0;
    end else if (hba_rst) begin
      gis <= '0;
      ghc <= '0;
    end else begin
      gis <= (gis & ~sum_clr) | pend_nx;
      if (wr && off == G_CTL) begin
        ghc         <= '0;
        ghc[CTL_AE] <= 1'b1;
        ghc[1:0]    <= wdata[1:0];
      end
    end
  end

  assign irq = (|gis) && ghc[CTL_IE];

  always_comb begin
    case (off)
      G_CAP:  rdata = CAP_VALUE;
      G_CTL:  rdata = ghc;
      G_SUM:  rdata = 32'(gis);
      G_IMPL: rdata = IMPL_VALUE;
      G_VER:  rdata = VER_VALUE;
      default: rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/sata_hba_regs.sv
module sata_hba_regs
  import sata_hba_pkg::*;
#(
  parameter int NP = 4,
  parameter int AW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic [NP-1:0]   dev_present,
  input  logic [NP*32-1:0] irq_evt,
  input  logic [NP*32-1:0] err_evt,
  input  logic [NP*32-1:0] fin_set,
  input  logic [NP*32-1:0] ci_clr,
  output logic            irq,
  output logic [NP*32-1:0] ci_o,
  output logic [NP-1:0]   port_start_o,
  output logic [NP-1:0]   port_fisrx_o,
  output logic [NP-1:0]   port_rst_o
);
  localparam int PIW = (NP > 1) ? $clog2(NP) : 1;
  localparam int PORT_END = PORT_BASE + (NP << PORT_SHIFT);

  logic [AW-1:0]  rel;
  logic [PIW-1:0] pidx;
  logic           aligned, in_glob, in_port;
  logic [31:0]    prdata [NP];
  logic [31:0]    grdata;
  logic [NP-1:0]  pend_nx, gis_q;
  logic [31:0]    ghc_q;
  logic           hba_rst;

  always_comb begin
    rel     = addr - AW'(PORT_BASE);
    pidx    = rel[PORT_SHIFT +: PIW];
    aligned = (addr[1:0] == 2'b00);
    in_glob = (int'(addr) < PORT_BASE);
    in_port = (int'(addr) >= PORT_BASE) && (int'(addr) < PORT_END);
  end

  sata_hba_global #(.NP(NP)) u_glob (
    .clk(clk), .rst_n(rst_n),
    .wr(wr_en && aligned && in_glob), .off(addr[7:0]), .wdata(wdata),
    .pend_nx(pend_nx), .rdata(grdata), .hba_rst(hba_rst), .irq(irq),
    .gis(gis_q), .ghc(ghc_q)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic sel;
    assign sel = in_port && (int'(pidx) == p);
    sata_port_regs u_port (
      .clk(clk), .rst_n(rst_n), .hba_rst(hba_rst),
      .wr(wr_en && aligned && sel), .rd(rd_en && sel),
      .off(addr[6:0]), .wdata(wdata), .dev_present(dev_present[p]),
      .evt(irq_evt[p*32 +: 32]), .err_in(err_evt[p*32 +: 32]),
      .fin_in(fin_set[p*32 +: 32]), .ci_clr(ci_clr[p*32 +: 32]),
      .rdata(prdata[p]), .pend_nx(pend_nx[p]), .ci(ci_o[p*32 +: 32]),
      .start_p(port_start_o[p]), .fisrx_p(port_fisrx_o[p]), .prst_p(port_rst_o[p])
    );
  end

  always_comb begin
    if (in_port)      rdata = prdata[pidx];
    else if (in_glob) rdata = grdata;
    else              rdata = 32'h0;
  end
endmodule

// File: rtl/sata_hba_regs_chk.sv
module sata_hba_regs_chk #(
  parameter int NP = 4,
  parameter int AW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [31:0]     wdata,
  input logic            irq,
  input logic [NP*32-1:0] ci_clr,
  input logic [NP*32-1:0] ci_o,
  input logic [NP-1:0]   port_start_o,
  input logic [NP-1:0]   port_rst_o,
  input logic [31:0]     ghc
);
  a_r2_unaligned_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[1:0] != 2'b00 && ci_clr == '0) |=> $stable(ci_o));

  a_r10_issue_or: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h138) && ci_clr[31:0] == 32'h0)
      |=> ((ci_o[31:0] & $past(wdata)) == $past(wdata)));

  a_r7_reset_all_ports: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h004) && wdata[0]) |=> (port_rst_o == '1 && ghc == 32'h0));

  a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h118)) |=> (port_start_o[0] == $past(wdata[0])));

  a_r6_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h004) && !wdata[1]) |=> !irq);
endmodule

bind sata_hba_regs sata_hba_regs_chk #(.NP(NP), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .ci_clr(ci_clr), .ci_o(ci_o), .port_start_o(port_start_o),
  .port_rst_o(port_rst_o), .ghc(ghc_q)
);

// File: tb/test_sata_hba_regs.sv
module test_sata_hba_regs;
  localparam int NP = 4;
  localparam int AW = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NP-1:0]   dev_present = 4'b0101;
  logic [NP*32-1:0] irq_evt = '0, err_evt = '0, fin_set = '0, ci_clr = '0;
  logic            irq;
  logic [NP*32-1:0] ci_o;
  logic [NP-1:0]   port_start_o, port_fisrx_o, port_rst_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  sata_hba_regs #(.NP(NP), .AW(AW)) i_sata_hba_regs (.*);

  function automatic logic [AW-1:0] pa(input int p, input int off);
    return AW'('h100 + p * 'h80 + off);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #2 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse_vec(input int which, input int p, input logic [31:0] bits);
    @(negedge clk);
    case (which)
      0: irq_evt[p*32 +: 32] = bits;
      1: err_evt[p*32 +: 32] = bits;
      2: fin_set[p*32 +: 32] = bits;
      default: ci_clr[p*32 +: 32] = bits;
    endcase
    @(negedge clk);
    irq_evt = '0; err_evt = '0; fin_set = '0; ci_clr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h1234_5678; pats[2] = 32'hA5A5_A5A5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R14 constants, R6/R7 reset state
    rdchk("R14 cap", 'h00, 32'h4014_1F03);
    rdchk("R14 impl", 'h0C, 32'h0000_000F);
    rdchk("R14 ver", 'h10, 32'h0001_0000);
    rdchk("R7 ctl reset", 'h04, 32'h0);
    rdchk("R5 sum reset", 'h08, 32'h0);
    chk("R6 irq reset", {31'h0, irq}, 32'h0);
    for (int p = 0; p < NP; p++) begin
      rdchk("R8 cmd reset", pa(p, 'h18), 32'h6);
      rdchk("R13 link status", pa(p, 'h28), dev_present[p] ? 32'h113 : 32'h0);
      wr(pa(p, 'h28), 32'hFFFF_FFFF);
      rdchk("R13 write ignored", pa(p, 'h28), dev_present[p] ? 32'h113 : 32'h0);
    end

    // R1 decode sweep, no aliasing
    for (int p = 0; p < NP; p++)
      for (int o = 0; o < 4; o++) wr(pa(p, o * 4), 32'(p * 'h1000 + o * 'h10 + 'h7));
    for (int p = 0; p < NP; p++)
      for (int o = 0; o < 4; o++)
        rdchk("R1 base sweep", pa(p, o * 4), 32'(p * 'h1000 + o * 'h10 + 'h7));
    wr(pa(2, 'h24), 32'hCAFE_0101);
    rdchk("R1 signature", pa(2, 'h24), 32'hCAFE_0101);
    wr(pa(2, 'h20), 32'hABCD_1234);
    rdchk("R1 taskfile 16b", pa(2, 'h20), 32'h0000_1234);
    wr(pa(NP, 0), 32'h5555_5555);
    rdchk("R1 past last port", pa(NP, 0), 32'h0);
    rdchk("R1 last port intact", pa(NP - 1, 0), 32'(3 * 'h1000 + 'h7));
    rdchk("R1 unknown global", 'h20, 32'h0);

    // R2 unaligned write
    wr(pa(0, 1), 32'hDEAD_BEEF);
    rdchk("R2 unaligned dropped", pa(0, 0), 32'h7);

    // R4 enable mask sweep
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < 3; k++) begin
        wr(pa(p, 'h14), pats[k]);
        rdchk("R4 enable mask", pa(p, 'h14), pats[k] & 32'hFDC0_00FF);
      end
      wr(pa(p, 'h14), 32'h0);
    end

    // R3 status
    pulse_vec(0, 1, 32'h0000_00F0);
    rdchk("R3 event set", pa(1, 'h10), 32'hF0);
    wr(pa(1, 'h10), 32'h30);
    rdchk("R3 w1c", pa(1, 'h10), 32'hC0);
    wr(pa(1, 'h10), 32'hFFFF_FFFF);
    rdchk("R3 clear all", pa(1, 'h10), 32'h0);
    rdchk("R5 masked no summary", 'h08, 32'h0);

    // R5 / R6 summary and irq
    wr(pa(2, 'h14), 32'h1);
    pulse_vec(0, 2, 32'h1);
    rdchk("R5 summary set", 'h08, 32'h4);
    chk("R6 irq gated off", {31'h0, irq}, 32'h0);
    wr('h04, 32'h2);
    rdchk("R7 ctl store", 'h04, 32'h8000_0002);
    chk("R6 irq on", {31'h0, irq}, 32'h1);
    wr('h08, 32'h4);
    rdchk("R5 repend", 'h08, 32'h4);
    wr(pa(2, 'h10), 32'h1);
    rdchk("R5 sticky", 'h08, 32'h4);
    wr('h08, 32'h4);
    rdchk("R5 cleared", 'h08, 32'h0);
    chk("R6 irq off when empty", {31'h0, irq}, 32'h0);
    pulse_vec(0, 2, 32'h1);
    chk("R6 irq again", {31'h0, irq}, 32'h1);
    wr('h04, 32'h0);
    chk("R6 irq disabled", {31'h0, irq}, 32'h0);
    rdchk("R7 ctl ae", 'h04, 32'h8000_0000);
    wr(pa(2, 'h10), 32'h1);
    wr('h08, 32'hF);

    // R8 / R9 command
    wr(pa(3, 'h18), 32'h1);
    chk("R8 start pulse", {28'h0, port_start_o}, 32'h8);
    rdchk("R8 cmd running", pa(3, 'h18), 32'h8001);
    wr(pa(3, 'h18), 32'hC000);
    chk("R8 no start", {28'h0, port_start_o}, 32'h0);
    rdchk("R8 running cleared", pa(3, 'h18), 32'h0);
    wr(pa(3, 'h18), 32'h10);
    chk("R9 first receive pulse", {28'h0, port_fisrx_o}, 32'h8);
    rdchk("R8 fis running", pa(3, 'h18), 32'h4010);
    wr(pa(3, 'h18), 32'h0);
    wr(pa(3, 'h18), 32'h10);
    chk("R9 second no pulse", {28'h0, port_fisrx_o}, 32'h0);

    // R10 issue, active, error
    wr(pa(0, 'h38), 32'h3);
    wr(pa(0, 'h38), 32'h4);
    rdchk("R10 issue or", pa(0, 'h38), 32'h7);
    chk("R10 issue out", ci_o[31:0], 32'h7);
    pulse_vec(3, 0, 32'h1);
    rdchk("R10 issue clear", pa(0, 'h38), 32'h6);
    wr(pa(0, 'h34), 32'h5);
    wr(pa(0, 'h34), 32'h8);
    rdchk("R10 active or", pa(0, 'h34), 32'hD);
    pulse_vec(1, 0, 32'h0F0F);
    rdchk("R10 error set", pa(0, 'h30), 32'h0F0F);
    wr(pa(0, 'h30), 32'h0F00);
    rdchk("R10 error w1c", pa(0, 'h30), 32'h000F);

    // R12 completion record
    pulse_vec(2, 0, 32'h1);
    rdchk("R12 read clears done", pa(0, 'h34), 32'hC);
    rdchk("R12 record emptied", pa(0, 'h34), 32'hC);
    pulse_vec(2, 0, 32'h8);
    pulse_vec(2, 0, 32'h1);
    rdchk("R12 accumulate", pa(0, 'h34), 32'h4);

    // R11 link control reset
    wr(pa(0, 'h14), 32'hFF);
    pulse_vec(0, 0, 32'h1);
    wr(pa(0, 'h2C), 32'h1);
    chk("R11 no pulse on set", {28'h0, port_rst_o}, 32'h0);
    wr(pa(0, 'h2C), 32'h300);
    chk("R11 reset pulse", {28'h0, port_rst_o}, 32'h1);
    rdchk("R11 status cleared", pa(0, 'h10), 32'h0);
    rdchk("R11 enable cleared", pa(0, 'h14), 32'h0);
    rdchk("R11 active cleared", pa(0, 'h34), 32'h0);
    rdchk("R11 error cleared", pa(0, 'h30), 32'h0);
    rdchk("R11 ctl stored", pa(0, 'h2C), 32'h300);
    wr(pa(0, 'h2C), 32'h2);
    wr(pa(0, 'h2C), 32'h0);
    chk("R11 2 to 0 no pulse", {28'h0, port_rst_o}, 32'h0);
    wr(pa(3, 'h2C), 32'h1);
    wr(pa(3, 'h2C), 32'h0);
    wr(pa(3, 'h18), 32'h10);
    chk("R9 rearmed by reset", {28'h0, port_fisrx_o}, 32'h8);
    wr('h08, 32'hF);

    // R7 controller reset
    wr(pa(1, 'h14), 32'h1);
    pulse_vec(0, 1, 32'h1);
    wr('h04, 32'h2);
    wr('h04, 32'h3);
    chk("R7 all port pulses", {28'h0, port_rst_o}, 32'hF);
    chk("R7 irq low", {31'h0, irq}, 32'h0);
    rdchk("R7 ctl zero", 'h04, 32'h0);
    rdchk("R7 summary zero", 'h08, 32'h0);
    rdchk("R7 enable zero", pa(1, 'h14), 32'h0);
    rdchk("R7 status zero", pa(1, 'h10), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule